// File: doc/BRIEF.md
# Custom-Instruction Interrupt Unit

This unit is the interrupt controller of a small 32-bit RISC-V core that has no machine-mode CSRs. It watches a bank of interrupt lines together with three internal sources: a timer event and two synchronous fault events. For each line it keeps a pending bit and a disable bit, and it holds one global "handler active" flag. Software reaches this state through instructions in the custom-0 opcode space. Those instructions move data between the register file and four shadow registers, rewrite the disable mask, return from a handler, and park the core until an interrupt arrives.

An interrupt is taken only on a cycle in which the core presents an instruction (`ins_valid`). The unit then takes the interrupt in place of that instruction. The instruction's PC goes into shadow register 0, and the bitmap of enabled pending sources goes into shadow register 1. Those bits leave the pending vector, the handler flag is set, and the core is redirected to a fixed vector. A fault that cannot be serviced, because its source is disabled or because a handler is already running, stops the core for good.

The unit has no registers at its output. Writeback, redirect and stall are decided in the same cycle from the presented instruction and the stored state. All state changes take effect at the next clock edge.

Top module: `cirq_unit`

## Requirements
- R1: After reset every source is disabled (mask all ones), nothing is pending, the handler flag is clear, and `stall`, `halted`, `wb_en` and `redirect_en` are all low.
- R2: A rising edge on `irq_lines[i]` sets pending bit i. When `ins_valid` is high, the handler flag is clear and some pending bit is enabled, the unit redirects to `VECTOR` (default 0x10). In that case shadow register 0 gets `ins_pc` and shadow register 1 gets the bitmap pending AND NOT disabled. A source whose disable bit is set is never taken.
- R3: Entry clears the serviced bits from the pending vector and sets the handler flag. While the flag is set, no further entry happens, and new edges only accumulate as pending.
- R4: With `LATCHED`=1 a pending bit survives its line falling. With `LATCHED`=0, a falling line also clears its pending bit.
- R5: retirq (funct7 0000010) redirects to shadow register 0, clears the handler flag, and ORs the lines that were high before this cycle into the pending vector.
- R6: maskirq (funct7 0000011) loads `rs1_val` into the disable mask. If rd = `ins_word[11:7]` is nonzero, it writes the previous mask to rd.
- R7: All instructions use opcode `ins_word[6:0]`=0001011 with funct7 = `ins_word[31:25]`. getq (0000000) writes shadow register `ins_word[16:15]` to rd, and writes nothing when rd is 0. setq (0000001) writes `rs1_val` into shadow register `ins_word[8:7]`.
- R8: `timer_evt` sets pending bit 0, `trap_evt` (illegal instruction, EBREAK, ECALL) sets bit 1, and `align_evt` (misaligned load or store) sets bit 2.
- R9: If bit 1 or bit 2 is pending while its disable bit is set or while the handler flag is set, the unit sets `halted` from the next cycle until reset. From then on it takes no interrupt and executes no instruction.
- R10: waitirq (funct7 0000100) raises `stall` from the next cycle if no enabled bit is pending. `stall` falls one cycle after an enabled bit becomes pending. While `stall` is high, `ins_valid` is ignored.
- R11: In an entry cycle the presented instruction has no effect: no writeback and no shadow or mask update.
- R12: A word with another opcode, or with any other funct7 (the timer funct7 0000101 included), changes no state and produces no writeback or redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NIRQ | Interrupt line levels |
| timer_evt | input | 1 | Timer expiry pulse (source 0) |
| trap_evt | input | 1 | Illegal/EBREAK/ECALL pulse (source 1) |
| align_evt | input | 1 | Misaligned access pulse (source 2) |
| ins_valid | input | 1 | An instruction is presented at a boundary |
| ins_word | input | 32 | Instruction word |
| ins_pc | input | XLEN | PC of the presented instruction |
| rs1_val | input | XLEN | Value of the rs1 register |
| wb_en | output | 1 | Register writeback this cycle |
| wb_addr | output | 5 | Writeback destination |
| wb_data | output | XLEN | Writeback value |
| redirect_en | output | 1 | PC redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| stall | output | 1 | Core parked by waitirq |
| halted | output | 1 | Core stopped on an unserviceable fault |

## Verification
The bench runs two instances side by side, one latched and one level-sensitive, under the same stimulus. It aims at the case where a line drops during a handler and a retirq follows while another line is still high. A unit that mixed up the two modes, or skipped the re-assertion, would save a wrong bitmap in shadow register 1 on the next entry. Other targets are an instruction collapsing into an entry cycle, which a faulty unit would let write back, and rd = 0 on getq and maskirq. The bench also checks a disabled line that must never be taken, waitirq release timing (an off-by-one design holds or drops `stall` one cycle early or late), and faults arriving both inside a handler and with all sources disabled, where a weak unit would take the fault instead of halting.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

    localparam logic [6:0] F7_GETQ    = 7'b0000000;
    localparam logic [6:0] F7_SETQ    = 7'b0000001;
    localparam logic [6:0] F7_RETIRQ  = 7'b0000010;
    localparam logic [6:0] F7_MASKIRQ = 7'b0000011;
    localparam logic [6:0] F7_WAITIRQ = 7'b0000100;

    localparam int QIDX_W = 2;

    localparam int SRC_TIMER = 0;
    localparam int SRC_TRAP  = 1;
    localparam int SRC_ALIGN = 2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GETQ,
        OP_SETQ,
        OP_RETIRQ,
        OP_MASKIRQ,
        OP_WAITIRQ
    } op_e;

    typedef struct packed {
        op_e               kind;
        logic [4:0]        rd;
        logic [QIDX_W-1:0] qsrc;
        logic [QIDX_W-1:0] qdst;
    } dec_t;

endpackage

// File: rtl/cirq_decode.sv
module cirq_decode
    import cirq_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] word,
    output dec_t        dec
);

    logic unused_bits;
    assign unused_bits = ^{word[24:17], word[14:12]};

    always_comb begin
        dec      = '0;
        dec.kind = OP_NONE;
        dec.rd   = word[11:7];
        dec.qsrc = word[15 +: QIDX_W];
        dec.qdst = word[7 +: QIDX_W];
        if (valid && word[6:0] == OPC_CUSTOM0) begin
            case (word[31:25])
                F7_GETQ:    dec.kind = OP_GETQ;
                F7_SETQ:    dec.kind = OP_SETQ;
                F7_RETIRQ:  dec.kind = OP_RETIRQ;
                F7_MASKIRQ: dec.kind = OP_MASKIRQ;
                F7_WAITIRQ: dec.kind = OP_WAITIRQ;
                default:    dec.kind = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cirq_qregs.sv
module cirq_qregs
    import cirq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_we,
    input  logic [XLEN-1:0]   entry_pc,
    input  logic [XLEN-1:0]   entry_map,
    input  logic              set_we,
    input  logic [QIDX_W-1:0] set_idx,
    input  logic [XLEN-1:0]   set_val,
    input  logic [QIDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]   rd_val,
    output logic [XLEN-1:0]   ret_pc
);

    localparam int NQ = 1 << QIDX_W;

    logic [XLEN-1:0] qs_d [NQ];
    logic [XLEN-1:0] qs_q [NQ];

    for (genvar gi = 0; gi < NQ; gi++) begin : g_q
        logic [XLEN-1:0] entry_val;
        if (gi == 0) begin : g_pc
            assign entry_val = entry_pc;
        end else if (gi == 1) begin : g_map
            assign entry_val = entry_map;
        end else begin : g_keep
            assign entry_val = qs_q[gi];
        end
        assign qs_d[gi] = entry_we ? entry_val :
                          (set_we && set_idx == QIDX_W'(gi)) ? set_val : qs_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) qs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NQ; i++) qs_q[i] <= qs_d[i];
        end
    end

    assign rd_val = qs_q[rd_idx];
    assign ret_pc = qs_q[0];

    a_r7_setq_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_we && !entry_we |=> qs_q[$past(set_idx)] == $past(set_val));

    a_r2_entry_saves_pc: assert property (@(posedge clk) disable iff (!rst_n)
        entry_we |=> qs_q[0] == $past(entry_pc) && qs_q[1] == $past(entry_map));

endmodule

// File: rtl/cirq_irq_state.sv
module cirq_irq_state
    import cirq_pkg::*;
#(
    parameter int NIRQ    = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] lines,
    input  logic            tmr_evt,
    input  logic            trap_evt,
    input  logic            align_evt,
    input  logic            ins_valid,
    input  op_e             op,
    input  logic [NIRQ-1:0] new_dis,
    output logic            take,
    output logic [NIRQ-1:0] serviced,
    output logic            exec,
    output logic [NIRQ-1:0] dis_mask,
    output logic            stall,
    output logic            halted
);

    localparam logic [NIRQ-1:0] EXC_BITS =
        (NIRQ'(1) << SRC_TRAP) | (NIRQ'(1) << SRC_ALIGN);

    typedef struct packed {
        logic [NIRQ-1:0] pend;
        logic [NIRQ-1:0] line;
        logic [NIRQ-1:0] dis;
        logic            inh;
        logic            waitf;
        logic            halt;
    } st_t;

    st_t st_d, st_q;

    logic [NIRQ-1:0] rise, drop, srcs, set_vec, exc_pend, pend_n;
    logic            exc_block, any_en;

    // Edge detection per line; the mode parameter picks how a fall acts.
    for (genvar gi = 0; gi < NIRQ; gi++) begin : g_edge
        assign rise[gi] = lines[gi] & ~st_q.line[gi];
        if (LATCHED) begin : g_latch
            assign drop[gi] = 1'b0;
        end else begin : g_level
            assign drop[gi] = st_q.line[gi] & ~lines[gi];
        end
    end

    assign srcs = (NIRQ'(tmr_evt)   << SRC_TIMER)
                | (NIRQ'(trap_evt)  << SRC_TRAP)
                | (NIRQ'(align_evt) << SRC_ALIGN);
    assign set_vec = rise | srcs;

    always_comb begin
        exc_pend  = st_q.pend & EXC_BITS;
        exc_block = (|exc_pend) && (st_q.inh || (|(st_q.dis & exc_pend)));
        serviced  = st_q.pend & ~st_q.dis;
        any_en    = |serviced;
        take      = ins_valid && !st_q.halt && !exc_block && !st_q.inh
                    && !st_q.waitf && any_en;
        exec      = ins_valid && !st_q.halt && !exc_block && !take && !st_q.waitf;

        st_d      = st_q;
        st_d.line = lines;
        st_d.halt = st_q.halt | exc_block;
        pend_n    = st_q.pend;

        if (take) begin
            pend_n   = pend_n & ~serviced;
            st_d.inh = 1'b1;
        end

        if (exec) begin
            case (op)
                OP_RETIRQ: begin
                    pend_n   = pend_n | st_q.line;
                    st_d.inh = 1'b0;
                end
                OP_MASKIRQ: st_d.dis = new_dis;
                OP_WAITIRQ: if (!any_en) st_d.waitf = 1'b1;
                default: ;
            endcase
        end

        if (st_q.waitf) st_d.waitf = !any_en;

        pend_n    = (pend_n & ~drop) | set_vec;
        st_d.pend = pend_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend  <= '0;
            st_q.line  <= '0;
            st_q.dis   <= '1;
            st_q.inh   <= 1'b0;
            st_q.waitf <= 1'b0;
            st_q.halt  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dis_mask = st_q.dis;
    assign stall    = st_q.waitf;
    assign halted   = st_q.halt;

    a_r3_entry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> st_q.inh);

    a_r3_serviced_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st_q.pend & $past(serviced) & ~$past(set_vec)) == '0);

    a_r5_return_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op == OP_RETIRQ |=> !st_q.inh);

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halt |=> st_q.halt);

    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.waitf && (|(st_q.pend & ~st_q.dis)) |=> !st_q.waitf);

    a_r6_mask_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op == OP_MASKIRQ |=> st_q.dis == $past(new_dis));

endmodule

// File: rtl/cirq_unit.sv
module cirq_unit
    import cirq_pkg::*;
#(
    parameter int          NIRQ    = 32,
    parameter int          XLEN    = 32,
    parameter bit          LATCHED = 1'b1,
    parameter logic [31:0] VECTOR  = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_lines,
    input  logic            timer_evt,
    input  logic            trap_evt,
    input  logic            align_evt,
    input  logic            ins_valid,
    input  logic [31:0]     ins_word,
    input  logic [XLEN-1:0] ins_pc,
    input  logic [XLEN-1:0] rs1_val,
    output logic            wb_en,
    output logic [4:0]      wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            redirect_en,
    output logic [XLEN-1:0] redirect_pc,
    output logic            stall,
    output logic            halted
);

    dec_t            dec;
    logic            take, exec;
    logic [NIRQ-1:0] serviced, dis_mask;
    logic [XLEN-1:0] q_rd, q_ret;
    logic            set_we, ret_do;

    cirq_decode u_dec (
        .valid (ins_valid),
        .word  (ins_word),
        .dec   (dec)
    );

    cirq_irq_state #(
        .NIRQ    (NIRQ),
        .LATCHED (LATCHED)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (irq_lines),
        .tmr_evt   (timer_evt),
        .trap_evt  (trap_evt),
        .align_evt (align_evt),
        .ins_valid (ins_valid),
        .op        (dec.kind),
        .new_dis   (rs1_val[NIRQ-1:0]),
        .take      (take),
        .serviced  (serviced),
        .exec      (exec),
        .dis_mask  (dis_mask),
        .stall     (stall),
        .halted    (halted)
    );

    assign set_we = exec && dec.kind == OP_SETQ;
    assign ret_do = exec && dec.kind == OP_RETIRQ;

    cirq_qregs #(
        .XLEN (XLEN)
    ) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .entry_we  (take),
        .entry_pc  (ins_pc),
        .entry_map (XLEN'(serviced)),
        .set_we    (set_we),
        .set_idx   (dec.qdst),
        .set_val   (rs1_val),
        .rd_idx    (dec.qsrc),
        .rd_val    (q_rd),
        .ret_pc    (q_ret)
    );

    always_comb begin
        wb_en   = exec && (dec.kind == OP_GETQ || dec.kind == OP_MASKIRQ)
                  && dec.rd != 5'd0;
        wb_addr = dec.rd;
        wb_data = (dec.kind == OP_GETQ) ? q_rd : XLEN'(dis_mask);
        redirect_en = take || ret_do;
        redirect_pc = take ? XLEN'(VECTOR) : q_ret;
    end

    a_r11_single_effect: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, redirect_en}));

    a_r7_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_addr != 5'd0);

    a_r9_halted_silent: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !wb_en && !redirect_en);

endmodule

// File: tb/test_cirq_unit.sv
module test_cirq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] L = '0;
    logic        tmr = 1'b0, ei = 1'b0, em = 1'b0, iv = 1'b0;
    logic [31:0] word = '0, rs1 = '0, pc = '0;

    logic        wb_en_o [2];
    logic [4:0]  wb_addr_o [2];
    logic [31:0] wb_data_o [2];
    logic        red_en_o [2];
    logic [31:0] red_pc_o [2];
    logic        stall_o [2];
    logic        halt_o [2];

    int    nchk = 0, nerr = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state: index 0 latched, index 1 level
    logic [31:0] mp [2], ml [2], md [2];
    logic [31:0] mq [2][4];
    bit          mi [2], mw [2], mh [2];

    always #5 clk = ~clk;

    cirq_unit #(.LATCHED(1'b1)) i_cirq_unit (
        .clk(clk), .rst_n(rst_n), .irq_lines(L), .timer_evt(tmr),
        .trap_evt(ei), .align_evt(em), .ins_valid(iv), .ins_word(word),
        .ins_pc(pc), .rs1_val(rs1), .wb_en(wb_en_o[0]), .wb_addr(wb_addr_o[0]),
        .wb_data(wb_data_o[0]), .redirect_en(red_en_o[0]), .redirect_pc(red_pc_o[0]),
        .stall(stall_o[0]), .halted(halt_o[0]));

    cirq_unit #(.LATCHED(1'b0)) i_cirq_unit_lvl (
        .clk(clk), .rst_n(rst_n), .irq_lines(L), .timer_evt(tmr),
        .trap_evt(ei), .align_evt(em), .ins_valid(iv), .ins_word(word),
        .ins_pc(pc), .rs1_val(rs1), .wb_en(wb_en_o[1]), .wb_addr(wb_addr_o[1]),
        .wb_data(wb_data_o[1]), .redirect_en(red_en_o[1]), .redirect_pc(red_pc_o[1]),
        .stall(stall_o[1]), .halted(halt_o[1]));

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            mp[m] = '0; ml[m] = '0; md[m] = '1;
            mi[m] = 1'b0; mw[m] = 1'b0; mh[m] = 1'b0;
            for (int k = 0; k < 4; k++) mq[m][k] = '0;
        end
    endtask

    task automatic model_step();
        for (int m = 0; m < 2; m++) begin
            logic [31:0] serv, ep, pn, e_wd, e_pc;
            bit blk, tk, ex, isc, e_we, e_red;
            logic [6:0] f7;
            logic [4:0] rd;
            logic [1:0] qs, qd;
            serv = mp[m] & ~md[m];
            ep   = mp[m] & 32'h6;
            blk  = (ep != 0) && (mi[m] || ((md[m] & ep) != 0));
            tk   = iv && !mh[m] && !blk && !mi[m] && !mw[m] && serv != 0;
            ex   = iv && !mh[m] && !blk && !tk && !mw[m];
            isc  = word[6:0] == 7'b0001011;
            f7 = word[31:25]; rd = word[11:7]; qs = word[16:15]; qd = word[8:7];
            e_we = 1'b0; e_wd = '0; e_red = tk; e_pc = 32'h10;
            if (ex && isc) begin
                if (f7 == 7'd0 && rd != 0) begin e_we = 1'b1; e_wd = mq[m][qs]; end
                if (f7 == 7'd3 && rd != 0) begin e_we = 1'b1; e_wd = md[m]; end
                if (f7 == 7'd2) begin e_red = 1'b1; e_pc = mq[m][0]; end
            end
            chk($sformatf("inst%0d wb_en", m), 32'(wb_en_o[m]), 32'(e_we));
            if (e_we) begin
                chk($sformatf("inst%0d wb_addr", m), 32'(wb_addr_o[m]), 32'(rd));
                chk($sformatf("inst%0d wb_data", m), wb_data_o[m], e_wd);
            end
            chk($sformatf("inst%0d redirect_en", m), 32'(red_en_o[m]), 32'(e_red));
            if (e_red) chk($sformatf("inst%0d redirect_pc", m), red_pc_o[m], e_pc);
            chk($sformatf("inst%0d stall", m), 32'(stall_o[m]), 32'(mw[m]));
            chk($sformatf("inst%0d halted", m), 32'(halt_o[m]), 32'(mh[m]));
            if (!rst_n) continue;
            pn = mp[m];
            if (tk) begin
                pn = pn & ~serv; mq[m][0] = pc; mq[m][1] = serv; mi[m] = 1'b1;
            end
            if (mw[m]) mw[m] = (serv == 0);
            else if (ex && isc && f7 == 7'd4 && serv == 0) mw[m] = 1'b1;
            if (ex && isc) begin
                case (f7)
                    7'd1: mq[m][qd] = rs1;
                    7'd2: begin pn = pn | ml[m]; mi[m] = 1'b0; end
                    7'd3: md[m] = rs1;
                    default: ;
                endcase
            end
            if (m == 1) pn = pn & ~(ml[m] & ~L);
            pn = pn | (L & ~ml[m]) | {29'b0, em, ei, tmr};
            if (blk) mh[m] = 1'b1;
            mp[m] = pn;
            ml[m] = L;
        end
    endtask

    task automatic tick();
        #1;
        if (!rst_n) model_reset();
        model_step();
        @(posedge clk);
        @(negedge clk);
        iv = 1'b0; tmr = 1'b0; ei = 1'b0; em = 1'b0; word = '0; rs1 = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic logic [31:0] enc(logic [6:0] f7, logic [4:0] rs, logic [4:0] rd);
        return {f7, 5'd0, rs, 3'd0, rd, 7'b0001011};
    endfunction

    task automatic op(logic [31:0] w, logic [31:0] v, logic [31:0] p);
        iv = 1'b1; word = w; rs1 = v; pc = p;
        tick();
    endtask

    localparam logic [31:0] EN_MASK = ~32'h0000_010F;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        cur_req = "R1"; idle(2);
        rst_n = 1'b1;   idle(2);

        // R1 / R6: reset mask read back, rd=0 suppressed, then readback of new mask
        cur_req = "R1"; op(enc(7'd3, 5'd1, 5'd5), EN_MASK, 32'h4);
        cur_req = "R6"; op(enc(7'd3, 5'd1, 5'd0), EN_MASK, 32'h8);
        op(enc(7'd3, 5'd1, 5'd3), EN_MASK, 32'hC);

        // R7: shadow register moves
        cur_req = "R7";
        op(enc(7'd1, 5'd4, 5'd2), 32'hA5A5_1234, 32'h10);
        op(enc(7'd1, 5'd4, 5'd3), 32'h0BAD_F00D, 32'h14);
        op(enc(7'd0, 5'd2, 5'd7), 0, 32'h18);
        op(enc(7'd0, 5'd3, 5'd0), 0, 32'h1C);
        op(enc(7'd0, 5'd3, 5'd9), 0, 32'h20);

        // R12: foreign words leave no trace
        cur_req = "R12";
        op(enc(7'd5, 5'd1, 5'd4), 32'hFFFF_FFFF, 32'h24);
        op({7'd3, 5'd0, 5'd1, 3'd0, 5'd6, 7'b0101011}, 32'h0, 32'h28);
        op(enc(7'h7F, 5'd1, 5'd6), 32'h0, 32'h2C);
        op({7'd1, 5'd0, 5'd1, 3'd0, 5'd2, 7'b0001111}, 32'h0, 32'h2E);
        op(enc(7'd3, 5'd1, 5'd3), EN_MASK, 32'h30);
        op(enc(7'd0, 5'd2, 5'd7), 0, 32'h34);

        // R2: disabled line stays untaken
        cur_req = "R2";
        L[20] = 1'b1; idle(2);
        op(enc(7'd0, 5'd2, 5'd7), 0, 32'h40);

        // R2 / R11: enabled line taken in place of a getq
        L[3] = 1'b1; idle(1);
        cur_req = "R11"; op(enc(7'd0, 5'd2, 5'd7), 0, 32'h100);
        cur_req = "R2";
        op(enc(7'd0, 5'd0, 5'd1), 0, 32'h10);
        op(enc(7'd0, 5'd1, 5'd2), 0, 32'h14);

        // R3: no re-entry inside a handler
        cur_req = "R3";
        L[8] = 1'b1; idle(1);
        op(enc(7'd0, 5'd0, 5'd1), 0, 32'h18);
        // R4: line 8 falls before service
        cur_req = "R4";
        L[8] = 1'b0; idle(1);

        // R5: return re-asserts line 3; next entry bitmap differs by mode
        cur_req = "R5";
        op(enc(7'd2, 5'd0, 5'd0), 0, 32'h1C);
        cur_req = "R4";
        op(enc(7'd0, 5'd0, 5'd1), 0, 32'h100);
        op(enc(7'd0, 5'd1, 5'd2), 0, 32'h10);
        L[3] = 1'b0;
        cur_req = "R5";
        op(enc(7'd2, 5'd0, 5'd0), 0, 32'h14);
        idle(1);

        // R8: each internal source lands on its own bit
        cur_req = "R8";
        tmr = 1'b1; idle(1);
        op(enc(7'd0, 5'd0, 5'd1), 0, 32'h200);
        op(enc(7'd0, 5'd1, 5'd2), 0, 32'h10);
        op(enc(7'd2, 5'd0, 5'd0), 0, 32'h14);
        ei = 1'b1; idle(1);
        op(enc(7'd0, 5'd0, 5'd1), 0, 32'h300);
        op(enc(7'd0, 5'd1, 5'd2), 0, 32'h10);
        op(enc(7'd2, 5'd0, 5'd0), 0, 32'h14);
        em = 1'b1; idle(1);
        op(enc(7'd0, 5'd0, 5'd1), 0, 32'h380);
        op(enc(7'd0, 5'd1, 5'd2), 0, 32'h10);
        op(enc(7'd2, 5'd0, 5'd0), 0, 32'h14);
        idle(1);

        // R10: park and release
        cur_req = "R10";
        op(enc(7'd4, 5'd0, 5'd0), 0, 32'h400);
        op(enc(7'd0, 5'd2, 5'd7), 0, 32'h404);
        idle(2);
        L[8] = 1'b1; idle(1);
        idle(2);
        op(enc(7'd0, 5'd1, 5'd2), 0, 32'h404);
        op(enc(7'd0, 5'd1, 5'd2), 0, 32'h10);
        L[8] = 1'b0;
        op(enc(7'd2, 5'd0, 5'd0), 0, 32'h14);
        idle(1);

        // R9: fault while a handler runs
        cur_req = "R9";
        L[3] = 1'b1; idle(1);
        op(enc(7'd0, 5'd0, 5'd1), 0, 32'h500);
        em = 1'b1; idle(1);
        idle(2);
        op(enc(7'd0, 5'd0, 5'd1), 0, 32'h10);
        op(enc(7'd2, 5'd0, 5'd0), 0, 32'h14);
        idle(2);

        // R9: fault with everything disabled after reset
        L = '0; rst_n = 1'b0; idle(2);
        rst_n = 1'b1; idle(1);
        ei = 1'b1; idle(3);
        op(enc(7'd3, 5'd1, 5'd5), 32'h0, 32'h600);
        idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule